// File: doc/BRIEF.md
# SPI Serial Port with Interrupt Control

This block is a full-duplex synchronous serial port. It moves 8-bit characters most significant bit first. As a master it generates the serial clock from a programmable divider of the system clock. As a slave it shifts on a serial clock supplied from outside, and it can optionally be gated by an active-low select input. Software drives it through a small register port: a control/status register, a data register that is the transmit buffer on writes and the receive buffer on reads, and two divider bytes. Two request lines, one for receive and one for transmit, signal the processor.

One port-enable bit turns the receive and transmit engines on and off together. When this bit is cleared, a character already on the wire runs to completion, and nothing new starts after it. Two reset inputs act on different bits:

- Power-up clear resets everything.
- Software reset reinitialises the flags, the interrupt enables and the shift engine. It leaves the port enable, the mode bits and the divider unchanged.

After either reset the transmit flag reads as set, which tells software the buffer is free.

All serial data pins are separate inputs and outputs. An output-enable signal tells the pad logic when `serOut` should drive the line.

Top module: `spi_port`

## Requirements
- R1: Register map. Address 0 is control/status:
  - bit0 master mode, bit1 four-pin, bit2 port enable, bit3 receive interrupt enable, bit4 transmit interrupt enable. These bits are writable.
  - bit5 receive flag and bit6 transmit flag. These bits are read-only.
  - bit7 reads 0.

  Writing address 1 loads the transmit buffer. Reading address 1 returns the receive buffer. Addresses 2 and 3 hold the low and high byte of the clock divider. `rxIrq` is high exactly when bits 5 and 3 are both set, and `txIrq` exactly when bits 6 and 4 are both set.
- R2: After power-up clear:
  - Address 0 reads 0x40, so only the transmit flag is set.
  - The divider reads 2, with address 2 = 2 and address 3 = 0.
  - `sclkOut`, `serOutEn`, `rxIrq` and `txIrq` are low.
- R3: Software reset clears the receive flag and both interrupt enables, and sets the transmit flag. The port enable, the mode bits and the divider keep their values.
- R4: The transmit flag clears on a write to address 1. It sets when the buffer is moved into the shift register. That move happens only while the port enable is set and no character is in progress.
- R5: The receive flag sets when the eighth bit of a character completes. A read of address 1 clears it.
- R6: Master clock and bit timing:
  - `sclkOut` idles low. Each clock period lasts the divider value in system clocks, and divider values 0 and 1 act as 2.
  - The clock is high for floor(divider/2) system clocks.
  - Each character has exactly 8 rising edges.
  - `serOut` presents the bits MSB first and changes after falling edges. `serIn` is sampled on rising edges.
- R7: In master mode, with `serOut` looped back to `serIn`, every one of the 256 byte values is received unchanged.
- R8: In slave mode the port shifts on `sclkIn`. It samples `serIn` on rising edges and presents the next transmit bit on `serOut` after each falling edge, MSB first.
- R9: In four-pin slave mode with `selN` high:
  - `serOutEn` is low.
  - Clock edges are ignored.
  - The bit count is held, so a character split by a deselect completes correctly once `selN` returns low.
- R10: Clearing the port enable during a character lets that character finish and set the receive flag. No further character starts while the port is disabled: the transmit flag stays clear and `sclkOut` makes no edges.
- R11: While disabled and idle in slave mode, clock edges on `sclkIn` change neither the receive buffer nor the receive flag.
- R12: In master mode the four-pin bit and `selN` have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRst | input | 1 | Power-up clear, synchronous, active high |
| swRst | input | 1 | Software reset, synchronous, active high |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (read side effects) |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| sclkOut | output | 1 | Serial clock driven in master mode |
| sclkIn | input | 1 | External serial clock used in slave mode |
| selN | input | 1 | Active-low slave select (four-pin slave) |
| serIn | input | 1 | Serial data in (from the slave as master, from the master as slave) |
| serOut | output | 1 | Serial data out |
| serOutEn | output | 1 | Output enable for `serOut` |

## Verification
The bench builds the block with its default 8-bit character and 16-bit divider. At these sizes a full sweep of all 256 character values in master loopback takes only a few thousand cycles. Divider settings 0 through 9 and one value above 255 are stepped through, which covers the low-value clamp, odd/even half-period splitting and the high byte. Thirty-two slave transfers, a deselect in the middle of a character, and a disable in the middle of a character cover the enable and select corner cases.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_DIVLO = 2'd2;
  localparam logic [1:0] ADDR_DIVHI = 2'd3;

  localparam int BIT_MASTER = 0;
  localparam int BIT_FOURPIN = 1;
  localparam int BIT_PORTEN = 2;
  localparam int BIT_RXIE = 3;
  localparam int BIT_TXIE = 4;

  typedef struct packed {
    logic txWrite;
    logic load;
    logic sample;
    logic shift;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       swRst,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] ctrlRdata,
  input  logic       sclkIn,
  input  logic       selN,
  output logic       sclkOut,
  output logic       serOutEn,
  output logic       rxIrq,
  output logic       txIrq,
  output dpStrobe_t  st
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic masterMode, fourPin, portEn, rxIe, txIe, rxFlag, txFlag;
  logic [DIV_W-1:0] divReg, divEff, lowHalf, highHalf, halfCnt;
  logic [15:0] divWide, divLoNext, divHiNext;
  logic busy, phaseHigh, sclkReg;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0] sclkPipe;
  logic [1:0] selPipe;
  logic sclkRise, sclkFall, selSync, slaveActive, edgesOk;
  logic wrCtrl, wrData, rdData, loadNow, halfDone;
  dpStrobe_t raw;

  assign wrCtrl = regWe && regAddr == ADDR_CTRL;
  assign wrData = regWe && regAddr == ADDR_DATA;
  assign rdData = regRe && regAddr == ADDR_DATA;

  assign divWide   = 16'(divReg);
  assign divLoNext = {divWide[15:8], regWdata};
  assign divHiNext = {regWdata, divWide[7:0]};
  assign divEff    = (divReg < DIV_W'(2)) ? DIV_W'(2) : divReg;
  assign highHalf  = divEff >> 1;
  assign lowHalf   = divEff - highHalf;

  // external clock and select synchronisers
  always_ff @(posedge clk) begin
    if (porRst) begin
      sclkPipe <= '0;
      selPipe  <= '1;
    end else begin
      sclkPipe <= {sclkPipe[1:0], sclkIn};
      selPipe  <= {selPipe[0], selN};
    end
  end

  assign sclkRise    = sclkPipe[1] && !sclkPipe[2];
  assign sclkFall    = !sclkPipe[1] && sclkPipe[2];
  assign selSync     = selPipe[1];
  assign slaveActive = !fourPin || !selSync;
  assign edgesOk     = (portEn || busy) && slaveActive && !masterMode;
  assign loadNow     = !busy && portEn && !txFlag;
  assign halfDone    = busy && masterMode && halfCnt == DIV_W'(1);

  always_comb begin
    raw.txWrite = wrData;
    raw.load    = loadNow;
    raw.sample  = masterMode ? (halfDone && !phaseHigh) : (edgesOk && sclkRise);
    raw.shift   = masterMode ? (halfDone && phaseHigh) : (edgesOk && sclkFall && busy);
    raw.commit  = raw.shift && bitCnt == LAST_BIT;
    st = swRst ? '0 : raw;
  end

  // configuration: only power-up clear touches mode, enable and divider
  always_ff @(posedge clk) begin
    if (porRst) begin
      masterMode <= 1'b0;
      fourPin    <= 1'b0;
      portEn     <= 1'b0;
      divReg     <= DIV_W'(2);
    end else begin
      if (wrCtrl) begin
        masterMode <= regWdata[BIT_MASTER];
        fourPin    <= regWdata[BIT_FOURPIN];
        portEn     <= regWdata[BIT_PORTEN];
      end
      if (regWe && regAddr == ADDR_DIVLO) divReg <= divLoNext[DIV_W-1:0];
      if (regWe && regAddr == ADDR_DIVHI) divReg <= divHiNext[DIV_W-1:0];
    end
  end

  // interrupt enables and flags: both resets act here
  always_ff @(posedge clk) begin
    if (porRst || swRst) begin
      rxIe   <= 1'b0;
      txIe   <= 1'b0;
      rxFlag <= 1'b0;
      txFlag <= 1'b1;
    end else begin
      if (wrCtrl) begin
        rxIe <= regWdata[BIT_RXIE];
        txIe <= regWdata[BIT_TXIE];
      end
      if (st.commit) rxFlag <= 1'b1;
      else if (rdData) rxFlag <= 1'b0;
      if (wrData) txFlag <= 1'b0;
      else if (st.load) txFlag <= 1'b1;
    end
  end

  // shift sequencer
  always_ff @(posedge clk) begin
    if (porRst || swRst) begin
      busy      <= 1'b0;
      phaseHigh <= 1'b0;
      sclkReg   <= 1'b0;
      bitCnt    <= '0;
      halfCnt   <= '0;
    end else if (masterMode) begin
      if (st.load) begin
        busy      <= 1'b1;
        phaseHigh <= 1'b0;
        sclkReg   <= 1'b0;
        bitCnt    <= '0;
        halfCnt   <= lowHalf;
      end else if (busy) begin
        if (halfDone) begin
          if (!phaseHigh) begin
            sclkReg   <= 1'b1;
            phaseHigh <= 1'b1;
            halfCnt   <= highHalf;
          end else begin
            sclkReg   <= 1'b0;
            phaseHigh <= 1'b0;
            halfCnt   <= lowHalf;
            if (st.commit) begin
              busy   <= 1'b0;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt - 1'b1;
        end
      end
    end else begin
      sclkReg   <= 1'b0;
      phaseHigh <= 1'b0;
      if (st.sample) busy <= 1'b1;
      if (st.shift) begin
        if (st.commit) begin
          busy   <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign sclkOut  = sclkReg;
  assign serOutEn = (portEn || busy) && (masterMode || slaveActive);
  assign rxIrq    = rxFlag && rxIe;
  assign txIrq    = txFlag && txIe;

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  ctrlRdata = {1'b0, txFlag, rxFlag, txIe, rxIe, portEn, fourPin, masterMode};
      ADDR_DIVLO: ctrlRdata = divWide[7:0];
      ADDR_DIVHI: ctrlRdata = divWide[15:8];
      default:    ctrlRdata = 8'h00;
    endcase
  end

  p_swrst_keeps_enable_r3: assert property (@(posedge clk) disable iff (porRst)
    (swRst && !wrCtrl) |=> (txFlag && !rxFlag && !rxIe && !txIe && portEn == $past(portEn)));

  p_tx_flag_on_load_r4: assert property (@(posedge clk) disable iff (porRst)
    (st.load && !wrData) |=> txFlag);

  p_rx_flag_on_done_r5: assert property (@(posedge clk) disable iff (porRst)
    st.commit |=> rxFlag);

  p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (porRst)
    !busy |-> !sclkOut);

  p_deselect_holds_r9: assert property (@(posedge clk) disable iff (porRst)
    (!masterMode && fourPin && selSync && !swRst) |=> ($stable(bitCnt) && $stable(busy)));

  p_no_start_disabled_r10: assert property (@(posedge clk) disable iff (porRst)
    (!portEn && !busy) |=> !busy);
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] wdata,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txBuf, shiftReg, rxBuf;
  logic sampleBit;

  always_ff @(posedge clk) begin
    if (porRst) begin
      txBuf     <= '0;
      shiftReg  <= '0;
      rxBuf     <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (st.txWrite) txBuf <= wdata;
      if (st.load) shiftReg <= txBuf;
      else if (st.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
      if (st.sample) sampleBit <= serIn;
      if (st.commit) rxBuf <= {shiftReg[DATA_W-2:0], sampleBit};
    end
  end

  assign serOut = shiftReg[DATA_W-1];
  assign rxData = rxBuf;

  p_load_not_mid_shift_r4: assert property (@(posedge clk) disable iff (porRst)
    !(st.load && st.shift));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       swRst,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       rxIrq,
  output logic       txIrq,
  output logic       sclkOut,
  input  logic       sclkIn,
  input  logic       selN,
  input  logic       serIn,
  output logic       serOut,
  output logic       serOutEn
);
  dpStrobe_t strobe;
  logic [7:0] ctrlRdata;
  logic [DATA_W-1:0] rxData;

  spi_port_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .porRst(porRst), .swRst(swRst),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .ctrlRdata(ctrlRdata), .sclkIn(sclkIn), .selN(selN),
    .sclkOut(sclkOut), .serOutEn(serOutEn), .rxIrq(rxIrq), .txIrq(txIrq),
    .st(strobe)
  );

  spi_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .porRst(porRst), .st(strobe),
    .wdata(regWdata[DATA_W-1:0]), .serIn(serIn),
    .serOut(serOut), .rxData(rxData)
  );

  assign regRdata = (regAddr == ADDR_DATA) ? 8'(rxData) : ctrlRdata;
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  logic clk = 1'b0;
  logic porRst, swRst, regWe, regRe, sclkIn, selN, serIn, slaveIn, loopBack;
  logic [1:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic rxIrq, txIrq, sclkOut, serOut, serOutEn;
  int checks = 0, fails = 0;
  int cyc = 0, riseTotal = 0, lastRise = 0, lastPeriod = 0, highW = 0;
  logic sclkPrev = 1'b0;
  logic [7:0] capMosi = 8'h00;

  always #10 clk = ~clk;

  assign serIn = loopBack ? serOut : slaveIn;

  spi_port uut (
    .clk(clk), .porRst(porRst), .swRst(swRst), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .rxIrq(rxIrq), .txIrq(txIrq), .sclkOut(sclkOut), .sclkIn(sclkIn),
    .selN(selN), .serIn(serIn), .serOut(serOut), .serOutEn(serOutEn)
  );

  // master clock monitor, sampled between edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclkOut === 1'b1 && sclkPrev === 1'b0) begin
      riseTotal  = riseTotal + 1;
      lastPeriod = cyc - lastRise;
      lastRise   = cyc;
      capMosi    = {capMosi[6:0], serOut};
    end
    if (sclkOut === 1'b0 && sclkPrev === 1'b1) highW = cyc - lastRise;
    sclkPrev = sclkOut;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRe = 1'b1; #1 d = regRdata;
    @(negedge clk); regRe = 1'b0; #1;
  endtask

  task automatic waitRx(input int lim);
    for (int i = 0; i < lim && rxIrq !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic slaveBit(input logic b, output logic o);
    slaveIn = b;
    repeat (8) @(negedge clk);
    o = serOut; sclkIn = 1'b1;
    repeat (8) @(negedge clk);
    sclkIn = 1'b0;
  endtask

  task automatic slaveByte(input logic [7:0] m, output logic [7:0] c);
    logic ob;
    for (int i = 7; i >= 0; i--) begin
      slaveBit(m[i], ob);
      c[i] = ob;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, cap, tx, m;
    int r0, eff;
    porRst = 1'b1; swRst = 1'b0; regWe = 1'b0; regRe = 1'b0; regAddr = 2'd0;
    regWdata = 8'h00; sclkIn = 1'b0; selN = 1'b1; slaveIn = 1'b0; loopBack = 1'b1;
    repeat (3) @(negedge clk);
    porRst = 1'b0;

    // R2 reset state
    rd(2'd0, d); chk("R2 ctrl after power-up", d, 8'h40);
    rd(2'd2, d); chk("R2 divider low", d, 2);
    rd(2'd3, d); chk("R2 divider high", d, 0);
    chk("R2 sclkOut idle", sclkOut, 0);
    chk("R2 serOutEn idle", serOutEn, 0);
    chk("R2 irqs low", {rxIrq, txIrq}, 0);

    // R1 transmit request, R3 software reset
    wr(2'd0, 8'h1D);
    #1 chk("R1 txIrq with flag and enable", txIrq, 1);
    chk("R1 rxIrq without flag", rxIrq, 0);
    @(negedge clk); swRst = 1'b1; @(negedge clk); swRst = 1'b0;
    rd(2'd0, d); chk("R3 swRst keeps enable and mode", d, 8'h45);
    chk("R3 txIrq after swRst", txIrq, 0);

    // R1/R5 receive flag and request
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h3C);
    repeat (40) @(negedge clk);
    rd(2'd0, d); chk("R5 rx flag set after char", d, 8'h65);
    chk("R1 rxIrq masked by enable", rxIrq, 0);
    wr(2'd0, 8'h0D);
    #1 chk("R1 rxIrq with flag and enable", rxIrq, 1);
    rd(2'd1, d); chk("R5 rx data", d, 8'h3C);
    chk("R5 rxIrq cleared by read", rxIrq, 0);
    rd(2'd0, d); chk("R5 flag cleared by read", d, 8'h4D);

    // R4 transmit flag while disabled, then on load
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h42);
    rd(2'd0, d); chk("R4 tx flag cleared by write", d, 8'h09);
    wr(2'd0, 8'h0D);
    waitRx(100);
    rd(2'd0, d); chk("R4 tx flag set after load", d, 8'h6D);
    rd(2'd1, d); chk("R4 data after enable", d, 8'h42);

    // R7/R6 full master loopback sweep
    for (int v = 0; v < 256; v++) begin
      r0 = riseTotal;
      wr(2'd1, 8'(v));
      waitRx(100);
      rd(2'd1, d);
      chk("R7 loopback data", d, v);
      chk("R6 MSB-first serOut", capMosi, v);
      chk("R6 eight clock pulses", riseTotal - r0, 8);
    end

    // R6 divider sweep
    for (int dv = 0; dv < 11; dv++) begin
      int div;
      div = (dv == 10) ? 259 : dv;
      wr(2'd2, 8'(div));
      wr(2'd3, 8'(div >> 8));
      eff = (div < 2) ? 2 : div;
      wr(2'd1, 8'hA5);
      waitRx(2400);
      rd(2'd1, d);
      chk("R6 data at divider", d, 8'hA5);
      chk("R6 clock period", lastPeriod, eff);
      chk("R6 clock high time", highW, eff / 2);
    end

    // R10 disable mid-character
    wr(2'd2, 8'd4); wr(2'd3, 8'd0);
    wr(2'd1, 8'h96);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h09);
    waitRx(200);
    rd(2'd1, d); chk("R10 char completes after disable", d, 8'h96);
    r0 = riseTotal;
    wr(2'd1, 8'h11);
    repeat (60) @(negedge clk);
    rd(2'd0, d); chk("R10 no new start while disabled", d, 8'h09);
    chk("R10 no clock edges while disabled", riseTotal - r0, 0);
    wr(2'd0, 8'h0D);
    waitRx(200);
    rd(2'd0, d); chk("R4 pending char loads on enable", d, 8'h6D);
    rd(2'd1, d); chk("R10 pending char data", d, 8'h11);

    // R12 four-pin bit and select ignored in master
    wr(2'd0, 8'h0F); selN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tx = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'h81;
      wr(2'd1, tx);
      waitRx(200);
      rd(2'd1, d); chk("R12 four-pin master data", d, tx);
    end

    // R8 slave transfers
    loopBack = 1'b0;
    wr(2'd0, 8'h04);
    for (int v = 0; v < 32; v++) begin
      m = 8'(v * 8 + 5);
      tx = ~m;
      wr(2'd1, tx);
      slaveByte(m, cap);
      rd(2'd1, d);
      chk("R8 slave receive", d, m);
      chk("R8 slave transmit", cap, tx);
    end

    // R9 four-pin slave deselect
    wr(2'd0, 8'h06);
    wr(2'd1, 8'h81);
    repeat (4) @(negedge clk);
    #1 chk("R9 output disabled when deselected", serOutEn, 0);
    slaveByte(8'h3C, cap);
    rd(2'd0, d); chk("R9 edges ignored when deselected", d, 8'h46);
    selN = 1'b0; repeat (8) @(negedge clk);
    #1 chk("R9 output enabled when selected", serOutEn, 1);
    m = 8'hC3;
    for (int i = 7; i >= 4; i--) begin
      logic ob;
      slaveBit(m[i], ob); cap[i] = ob;
    end
    repeat (8) @(negedge clk); selN = 1'b1; repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      logic ob;
      slaveBit(i[0], ob);
    end
    repeat (8) @(negedge clk); selN = 1'b0; repeat (8) @(negedge clk);
    for (int i = 3; i >= 0; i--) begin
      logic ob;
      slaveBit(m[i], ob); cap[i] = ob;
    end
    repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R9 split char received", d, 8'hC3);
    chk("R9 split char transmitted", cap, 8'h81);

    // R11 disabled slave ignores clock
    wr(2'd0, 8'h00);
    slaveByte(8'hFF, cap);
    rd(2'd0, d); chk("R11 no flag while disabled", d, 8'h40);
    rd(2'd1, d); chk("R11 rx buffer unchanged", d, 8'hC3);

    // R2 power-up clear clears enable
    wr(2'd0, 8'h1F);
    @(negedge clk); porRst = 1'b1; @(negedge clk); porRst = 1'b0;
    rd(2'd0, d); chk("R2 power-up clears enable", d, 8'h40);

    summary();
    $finish;
  end
endmodule